// File: doc/BRIEF.md
# Element Step Sequencer

This block produces the walk of element and sub-element indices for one vector loop. Software, or an issue stage, gives it a length, a sub-vector size code, two ordering bits (one for the source side, one for the destination side), a vertical-first flag and a parallelism hint. A `start` pulse clears the counters and opens the loop. The block then reports the current source pair (element, sub-element), the current destination pair, a marker on the last item of each hint group, and a flag on the last item of the loop.

In horizontal mode the position moves forward on every clock while the loop is open. In vertical-first mode the position stays fixed until `step_req_i` is high. The group marker tells the issue logic where a single issue has to stop. The source and destination walks move on the same strobe, but each has its own nesting order. The block only produces indices: execution, masks and remapping belong to other blocks.

Top module: `elem_step_seq`

## Requirements
- R1: After `start`, each source and destination element index runs over 0..len-1. Each sub-element index runs over 0..code, so code values 0,1,2,3 give 1,2,3,4 sub-elements. Every item of the loop is issued exactly once.
- R2: With an ordering bit at 0 the sub-element counter is the inner loop. It wraps to 0 on the same step that the element counter increments.
- R3: With `pack_i` = 1 the source walk makes the element counter the inner loop. The sub-element counter increments when the element counter wraps from len-1 to 0.
- R4: `unpack_i` selects the nesting of the destination walk, independently of `pack_i`.
- R5: In horizontal mode (`vfirst_i` = 0) the position advances on every clock edge while the loop is open.
- R6: In vertical-first mode the position holds its value on every edge where `step_req_i` is low, and advances by one item on every edge where it is high.
- R7: `done_o` is high exactly on the final item (element len-1, sub-element code) on both sides. The next advance clears all counters to 0 and drops `valid_o` and `done_o`.
- R8: A length of 0 raises `done_o` with `valid_o` low in the first cycle after `start`. No item is issued, and the next advance closes the loop.
- R9: With hint H>0, `group_end_o` marks the last item whose source element shares floor(src/H) with the items before it. Under source sub-inner ordering it also needs the last sub-element. With H=0 it marks only the final item.
- R10: After reset `valid_o`, `done_o` and `group_end_o` are low and all indices are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Clears counters and opens a loop |
| len_i | input | LEN_W | Number of elements |
| subvl_i | input | SUB_W | Sub-element count minus one |
| pack_i | input | 1 | Source walk: element counter innermost |
| unpack_i | input | 1 | Destination walk: element counter innermost |
| vfirst_i | input | 1 | Vertical-first: advance only on request |
| hint_i | input | HINT_W | Parallelism group size, 0 = none |
| step_req_i | input | 1 | Explicit step request in vertical-first mode |
| src_elem_o | output | LEN_W | Source element index |
| src_sub_o | output | SUB_W | Source sub-element index |
| dst_elem_o | output | LEN_W | Destination element index |
| dst_sub_o | output | SUB_W | Destination sub-element index |
| valid_o | output | 1 | Current indices belong to the loop |
| group_end_o | output | 1 | Current item closes a hint group |
| done_o | output | 1 | Current item is the last of the loop |

## Verification
The bench targets the following corner cases.
- Mixed nesting: source and destination use opposite orders. A design that shares one order between the two walks returns destination pairs that are transposed.
- Group boundaries: hint values that do not divide the length, and hint 0. A design that computes the group from the overall item count, or that ignores the tail of the last partial group, marks the wrong items.
- Vertical-first stalls: the stall pattern is irregular. A design that keeps moving without a request skips items in the expected queue.
- Loop edges: length 0, length 1 and the largest length. A design with an off-by-one on the final item issues an extra item or stays open after the loop ends.

// File: rtl/esq_pkg.sv
package esq_pkg;
   localparam int DEF_LEN_W  = 7;
   localparam int DEF_SUB_W  = 2;
   localparam int DEF_HINT_W = 7;

   typedef enum logic {
      ORD_SUB_INNER  = 1'b0,
      ORD_ELEM_INNER = 1'b1
   } nest_order_e;
endpackage

// File: rtl/esq_nest.sv
module esq_nest
   import esq_pkg::*;
#(
   parameter int LEN_W       = DEF_LEN_W,
   parameter int SUB_W       = DEF_SUB_W,
   parameter int HINT_W      = DEF_HINT_W,
   parameter bit TRACK_GROUP = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              adv,
   input  logic              live,
   input  logic [LEN_W-1:0]  len,
   input  logic [SUB_W-1:0]  sub_code,
   input  logic              inv,
   input  logic [HINT_W-1:0] hint,
   output logic [LEN_W-1:0]  elem,
   output logic [SUB_W-1:0]  sub,
   output logic              at_final,
   output logic              grp_end
);
   logic [LEN_W-1:0] elem_q, elem_d, len_m1;
   logic [SUB_W-1:0] sub_q, sub_d;
   logic             elem_last, sub_last, elem_step, elem_wrap;
   nest_order_e      order;

   assign len_m1    = len - 1'b1;
   assign elem_last = (elem_q == len_m1);
   assign sub_last  = (sub_q == sub_code);
   assign order     = inv ? ORD_ELEM_INNER : ORD_SUB_INNER;
   assign at_final  = elem_last && sub_last;

   always_comb begin
      elem_d    = elem_q;
      sub_d     = sub_q;
      elem_step = 1'b0;
      elem_wrap = 1'b0;
      case (order)
         ORD_SUB_INNER: begin
            if (sub_last) begin
               sub_d     = '0;
               elem_d    = elem_q + 1'b1;
               elem_step = 1'b1;
            end else begin
               sub_d = sub_q + 1'b1;
            end
         end
         default: begin
            if (elem_last) begin
               elem_d    = '0;
               sub_d     = sub_q + 1'b1;
               elem_wrap = 1'b1;
            end else begin
               elem_d    = elem_q + 1'b1;
               elem_step = 1'b1;
            end
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         elem_q <= '0;
         sub_q  <= '0;
      end else if (clear) begin
         elem_q <= '0;
         sub_q  <= '0;
      end else if (adv) begin
         elem_q <= elem_d;
         sub_q  <= sub_d;
      end
   end

   assign elem = elem_q;
   assign sub  = sub_q;

   generate
      if (TRACK_GROUP) begin : g_group
         logic [HINT_W-1:0] grp_q;
         logic              grp_at_end, boundary;

         assign grp_at_end = (hint != '0) && (grp_q == hint - 1'b1);
         assign boundary   = grp_at_end || elem_last;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               grp_q <= '0;
            end else if (clear) begin
               grp_q <= '0;
            end else if (adv) begin
               if (elem_wrap)
                  grp_q <= '0;
               else if (elem_step)
                  grp_q <= grp_at_end ? '0 : grp_q + 1'b1;
            end
         end

         assign grp_end = live &&
            ((hint == '0) ? at_final : (boundary && (inv || sub_last)));

         // R9: group position stays inside the hint window
         a_r9_grp_in_window: assert property (@(posedge clk) disable iff (!rst_n)
            (live && hint != '0) |-> (grp_q < hint));
      end else begin : g_no_group
         assign grp_end = 1'b0;
      end
   endgenerate

   // R1: indices stay inside the loop bounds while issuing
   a_r1_in_bounds: assert property (@(posedge clk) disable iff (!rst_n)
      live |-> (sub_q <= sub_code && elem_q < len));

   // R6: no movement without an advance or a clear
   a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!adv && !clear) |=> ($stable(elem_q) && $stable(sub_q)));
endmodule

// File: rtl/esq_ctl.sv
module esq_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic vfirst,
   input  logic step_req,
   input  logic len_zero,
   input  logic at_final,
   output logic valid,
   output logic done,
   output logic clear,
   output logic adv_cnt
);
   logic busy_q, adv;

   assign adv     = busy_q && (!vfirst || step_req);
   assign done    = busy_q && (len_zero || at_final);
   assign valid   = busy_q && !len_zero;
   assign clear   = start || (adv && done);
   assign adv_cnt = adv && !done && !start;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         busy_q <= 1'b0;
      else if (start)
         busy_q <= 1'b1;
      else if (adv && done)
         busy_q <= 1'b0;
   end

   // R7: an advance taken on the final item closes the loop
   a_r7_close: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && done && !start) |=> !busy_q);

   // R8: a zero-length loop never reports an item
   a_r8_no_items: assert property (@(posedge clk) disable iff (!rst_n)
      len_zero |-> !valid);
endmodule

// File: rtl/elem_step_seq.sv
module elem_step_seq
   import esq_pkg::*;
#(
   parameter int LEN_W  = DEF_LEN_W,
   parameter int SUB_W  = DEF_SUB_W,
   parameter int HINT_W = DEF_HINT_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [LEN_W-1:0]  len_i,
   input  logic [SUB_W-1:0]  subvl_i,
   input  logic              pack_i,
   input  logic              unpack_i,
   input  logic              vfirst_i,
   input  logic [HINT_W-1:0] hint_i,
   input  logic              step_req_i,
   output logic [LEN_W-1:0]  src_elem_o,
   output logic [SUB_W-1:0]  src_sub_o,
   output logic [LEN_W-1:0]  dst_elem_o,
   output logic [SUB_W-1:0]  dst_sub_o,
   output logic              valid_o,
   output logic              group_end_o,
   output logic              done_o
);
   generate
      if (LEN_W < 1 || LEN_W > 16) begin : g_bad_len
         $error("elem_step_seq: LEN_W must lie in 1..16");
      end
      if (SUB_W < 1 || SUB_W > 4) begin : g_bad_sub
         $error("elem_step_seq: SUB_W must lie in 1..4");
      end
      if (HINT_W < 1 || HINT_W > 16) begin : g_bad_hint
         $error("elem_step_seq: HINT_W must lie in 1..16");
      end
   endgenerate

   logic clear, adv_cnt, valid, done, len_zero;
   logic src_final, dst_final, src_gend, dst_gend_unused;

   assign len_zero = (len_i == '0);

   esq_ctl u_ctl (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .vfirst   (vfirst_i),
      .step_req (step_req_i),
      .len_zero (len_zero),
      .at_final (src_final),
      .valid    (valid),
      .done     (done),
      .clear    (clear),
      .adv_cnt  (adv_cnt)
   );

   esq_nest #(.LEN_W(LEN_W), .SUB_W(SUB_W), .HINT_W(HINT_W), .TRACK_GROUP(1'b1)) u_src (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (clear),
      .adv      (adv_cnt),
      .live     (valid),
      .len      (len_i),
      .sub_code (subvl_i),
      .inv      (pack_i),
      .hint     (hint_i),
      .elem     (src_elem_o),
      .sub      (src_sub_o),
      .at_final (src_final),
      .grp_end  (src_gend)
   );

   esq_nest #(.LEN_W(LEN_W), .SUB_W(SUB_W), .HINT_W(HINT_W), .TRACK_GROUP(1'b0)) u_dst (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (clear),
      .adv      (adv_cnt),
      .live     (valid),
      .len      (len_i),
      .sub_code (subvl_i),
      .inv      (unpack_i),
      .hint     (hint_i),
      .elem     (dst_elem_o),
      .sub      (dst_sub_o),
      .at_final (dst_final),
      .grp_end  (dst_gend_unused)
   );

   assign valid_o     = valid;
   assign done_o      = done;
   assign group_end_o = src_gend;

   // R7: both walks reach their last item together
   a_r7_lockstep: assert property (@(posedge clk) disable iff (!rst_n)
      valid |-> (src_final == dst_final));

   // R5: horizontal mode moves on every edge until the final item
   a_r5_moves: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && !vfirst_i && !done && !start) |=>
         !($stable(src_elem_o) && $stable(src_sub_o)));

   // R9: group marker is always present on the final item
   a_r9_final_closes: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && done) |-> group_end_o);
endmodule

// File: tb/sim_elem_step_seq.sv
module sim_elem_step_seq;
   localparam int CLK_PERIOD = 10;
   localparam int LW = 7;
   localparam int SW = 2;
   localparam int HW = 7;

   typedef struct packed {
      logic [LW-1:0] se;
      logic [SW-1:0] ss;
      logic [LW-1:0] de;
      logic [SW-1:0] ds;
      logic          gend;
      logic          done;
   } item_t;

   logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
   logic [LW-1:0] len_i = '0;
   logic [SW-1:0] subvl_i = '0;
   logic pack_i = 1'b0, unpack_i = 1'b0, vfirst_i = 1'b0, step_req_i = 1'b0;
   logic [HW-1:0] hint_i = '0;
   logic [LW-1:0] src_elem_o, dst_elem_o;
   logic [SW-1:0] src_sub_o, dst_sub_o;
   logic valid_o, group_end_o, done_o;

   int tests = 0, fails = 0, cycles = 0;
   bit mon_en = 1'b0;
   item_t exp_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   elem_step_seq #(.LEN_W(LW), .SUB_W(SW), .HINT_W(HW)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .len_i(len_i), .subvl_i(subvl_i),
      .pack_i(pack_i), .unpack_i(unpack_i), .vfirst_i(vfirst_i), .hint_i(hint_i),
      .step_req_i(step_req_i), .src_elem_o(src_elem_o), .src_sub_o(src_sub_o),
      .dst_elem_o(dst_elem_o), .dst_sub_o(dst_sub_o), .valid_o(valid_o),
      .group_end_o(group_end_o), .done_o(done_o));

   task automatic chk(input bit ok, input string req, input string act, input string exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%s expected=%s", req, act, exp);
      end
   endtask

   // monitor: compares each issued item with the scoreboard front
   always @(negedge clk) begin
      if (mon_en && rst_n) begin
         if (valid_o) begin
            if (exp_q.size() == 0) begin
               chk(1'b0, "R1/R8 extra item", "valid=1", "no item");
            end else begin
               item_t a, e;
               string tag;
               a = '{src_elem_o, src_sub_o, dst_elem_o, dst_sub_o, group_end_o, done_o};
               e = exp_q[0];
               tag = "R1";
               if ({a.se, a.ss} != {e.se, e.ss}) tag = {tag, pack_i ? " R3" : " R2"};
               if ({a.de, a.ds} != {e.de, e.ds}) tag = {tag, unpack_i ? " R4" : " R2"};
               if (a.gend != e.gend) tag = {tag, " R9"};
               if (a.done != e.done) tag = {tag, " R7"};
               if (vfirst_i && !step_req_i) tag = {tag, " R6"};
               else if (!vfirst_i) tag = {tag, " R5"};
               chk(a == e, tag,
                   $sformatf("s(%0d,%0d) d(%0d,%0d) g%0d d%0d", a.se, a.ss, a.de, a.ds, a.gend, a.done),
                   $sformatf("s(%0d,%0d) d(%0d,%0d) g%0d d%0d", e.se, e.ss, e.de, e.ds, e.gend, e.done));
               if (!vfirst_i || step_req_i) void'(exp_q.pop_front());
            end
         end
      end
   end

   task automatic build(input int len, input int code, input bit pk, input bit upk, input int h);
      int se[$], ss[$], de[$], ds[$];
      int n;
      for (int a = 0; a < (pk ? code + 1 : len); a++)
         for (int b = 0; b < (pk ? len : code + 1); b++) begin
            se.push_back(pk ? b : a);
            ss.push_back(pk ? a : b);
         end
      for (int a = 0; a < (upk ? code + 1 : len); a++)
         for (int b = 0; b < (upk ? len : code + 1); b++) begin
            de.push_back(upk ? b : a);
            ds.push_back(upk ? a : b);
         end
      n = len * (code + 1);
      for (int i = 0; i < n; i++) begin
         item_t it;
         it.se = se[i][LW-1:0];
         it.ss = ss[i][SW-1:0];
         it.de = de[i][LW-1:0];
         it.ds = ds[i][SW-1:0];
         if (h == 0) it.gend = (i == n - 1);
         else it.gend = (((se[i] % h) == h - 1) || se[i] == len - 1) && (pk || ss[i] == code);
         it.done = (i == n - 1);
         exp_q.push_back(it);
      end
   endtask

   task automatic run_loop(input int len, input int code, input bit pk, input bit upk,
                           input bit vf, input int h);
      int k = 0;
      build(len, code, pk, upk, h);
      @(posedge clk); #1;
      len_i = len[LW-1:0]; subvl_i = code[SW-1:0]; pack_i = pk; unpack_i = upk;
      vfirst_i = vf; hint_i = h[HW-1:0]; step_req_i = 1'b0; start = 1'b1;
      @(posedge clk); #1;
      start = 1'b0;
      while (exp_q.size() != 0 && k < 5000) begin
         if (vf) step_req_i = ((k % 3) != 1) && ((k % 7) != 4); // R6 irregular stalls
         @(posedge clk); #1;
         k++;
      end
      chk(exp_q.size() == 0, "R1 all items issued", $sformatf("%0d left", exp_q.size()), "0 left");
      exp_q.delete();
      step_req_i = 1'b0;
      @(negedge clk);
      chk(!valid_o && !done_o, "R7 loop closed after final advance",
          $sformatf("v%0d d%0d", valid_o, done_o), "v0 d0");
   endtask

   initial begin
      #(CLK_PERIOD * 3);
      // R10: reset state
      chk(!valid_o && !done_o && !group_end_o && src_elem_o == 0 && dst_elem_o == 0 &&
          src_sub_o == 0 && dst_sub_o == 0, "R10 reset state",
          $sformatf("v%0d d%0d g%0d", valid_o, done_o, group_end_o), "all zero");
      @(posedge clk); #1 rst_n = 1'b1;
      mon_en = 1'b1;
      run_loop(5, 0, 0, 0, 0, 0);   // R2 R5 plain horizontal
      run_loop(3, 2, 1, 0, 0, 2);   // R3 source inverted, R9 partial group
      run_loop(4, 1, 0, 1, 1, 3);   // R4 R6 vertical-first, destination inverted
      run_loop(6, 3, 1, 1, 1, 4);   // R3 R4 R9 both inverted
      run_loop(7, 1, 0, 0, 0, 2);   // R9 sub-inner grouping
      run_loop(1, 0, 0, 1, 1, 1);   // R7 single item
      run_loop(127, 3, 0, 1, 0, 0); // R1 largest length
      // R8: zero length
      @(posedge clk); #1;
      len_i = '0; vfirst_i = 1'b0; start = 1'b1;
      @(posedge clk); #1 start = 1'b0;
      @(negedge clk);
      chk(done_o && !valid_o, "R8 zero length done at once",
          $sformatf("d%0d v%0d", done_o, valid_o), "d1 v0");
      @(negedge clk);
      chk(!done_o && !valid_o, "R8 zero length closes",
          $sformatf("d%0d v%0d", done_o, valid_o), "d0 v0");
      mon_en = 1'b0;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      while (cycles < 150000) begin
         @(posedge clk);
         cycles++;
      end
      tests++;
      fails++;
      $display("FAIL watchdog actual=%0d cycles expected=finish", cycles);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule